// File: doc/BRIEF.md
# Conditional Relative Branch Unit

This block decides whether a conditional branch is taken and works out the address that executes next. Each request carries a 3-bit condition select, the four status flags (negative, overflow, carry, zero), the 16-bit address of the instruction after the branch, and a one-byte signed displacement. The block picks one flag and tests it for set or clear. If the branch is taken, it adds the sign-extended displacement to the follow-on address. If not, it passes the follow-on address through unchanged.

The result is registered. A request strobed with `in_valid` appears on `out_valid`, `taken` and `target` on the next clock edge. The registered `taken` and `target` keep their values until the next request. A sequencer can therefore issue a request on every cycle, or leave gaps between requests.

Top module: `brx_branch_unit`

## Requirements
- R1: While `rst_n` is low, and after it is released until the first request, `out_valid` is 0, `taken` is 0 and `target` is 0x0000.
- R2: `out_valid` is 1 in the cycle after a cycle in which `in_valid` was 1, and 0 in every other cycle.
- R3: `cond_sel[2:1]` picks the flag to test: 00 negative, 01 overflow, 10 carry, 11 zero. `cond_sel[0]` = 1 means the branch is taken when that flag is set. `cond_sel[0]` = 0 means it is taken when that flag is clear. All eight codes are supported.
- R4: For a taken branch, `target` equals `next_pc` plus the displacement, where `offset` is read as two's complement (-128..+127) and sign-extended to 16 bits.
- R5: For a branch that is not taken, `target` equals `next_pc`, whatever the value of `offset`.
- R6: A taken branch with `offset` = 0x00 gives `target` = `next_pc`.
- R7: Taken targets that cross a 256-byte page, forward or backward, are correct. This includes the extremes +127 (0x7F) and -128 (0x80).
- R8: Target arithmetic wraps modulo 2^16 in both directions. For example, 0xFFF0 + 0x20 gives 0x0010, and 0x0005 - 16 gives 0xFFF5.
- R9: In a cycle in which `in_valid` is 0, `taken` and `target` keep their previous values on the next edge.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| in_valid | input | 1 | Request strobe |
| cond_sel | input | 3 | Condition code (flag select and polarity) |
| flag_n | input | 1 | Negative flag |
| flag_v | input | 1 | Overflow flag |
| flag_z | input | 1 | Zero flag |
| flag_c | input | 1 | Carry flag |
| next_pc | input | 16 | Address of the instruction after the branch |
| offset | input | 8 | Signed displacement byte |
| out_valid | output | 1 | Result strobe, one cycle after `in_valid` |
| taken | output | 1 | Branch decision |
| target | output | 16 | Address to execute next |

## Verification
Every result is due exactly one clock edge after its request. The bench drives each request just after a falling edge. It records the expected decision and address in a scoreboard queue at the moment it drives the request. The monitor pops the queue at the next falling edge, which comes after the single register stage. It compares `out_valid`, `taken` and `target` there. During gaps, the checks at the falling edge look for a low `out_valid` and for unchanged `taken` and `target`.

// File: rtl/brx_pkg.sv
package brx_pkg;

    // Position of each status flag inside the packed flag vector.
    // The order is the one decoded by cond_sel[2:1].
    typedef enum logic [1:0] {
        FLG_NEG = 2'd0,
        FLG_OVF = 2'd1,
        FLG_CRY = 2'd2,
        FLG_ZRO = 2'd3
    } flag_idx_e;

    localparam int FLAG_CNT = 4;

    // Target adder variants
    localparam int ADD_FULL  = 0;
    localparam int ADD_SPLIT = 1;

endpackage

// File: rtl/brx_cond_eval.sv
module brx_cond_eval
    import brx_pkg::*;
(
    input  logic [2:0]          cond_sel,
    input  logic [FLAG_CNT-1:0] flags,
    output logic                cond_true
);

    flag_idx_e flag_pick;
    logic      want_set;
    logic      flag_val;

    always_comb begin
        flag_pick = flag_idx_e'(cond_sel[2:1]);
        want_set  = cond_sel[0];
        flag_val  = flags[flag_pick];
        cond_true = (flag_val == want_set);
    end

endmodule

// File: rtl/brx_target_add.sv
module brx_target_add
    import brx_pkg::*;
#(
    parameter int PC_W      = 16,
    parameter int OFS_W     = 8,
    parameter int ADD_STYLE = ADD_SPLIT
) (
    input  logic [PC_W-1:0]  base_pc,
    input  logic [OFS_W-1:0] disp,
    output logic [PC_W-1:0]  sum_pc
);

    localparam int HI_W = PC_W - OFS_W;

    generate
        if (ADD_STYLE == ADD_FULL) begin : g_full
            logic [PC_W-1:0] disp_ext;
            always_comb begin
                disp_ext = {{HI_W{disp[OFS_W-1]}}, disp};
                sum_pc   = base_pc + disp_ext;
            end
        end else begin : g_split
            // Low part add, then a +1/-1/0 adjust of the upper part
            logic [OFS_W:0]  low_sum;
            logic [HI_W-1:0] hi_base;
            logic [HI_W-1:0] hi_adj;
            logic            lo_carry;
            logic            disp_neg;
            always_comb begin
                low_sum  = {1'b0, base_pc[OFS_W-1:0]} + {1'b0, disp};
                lo_carry = low_sum[OFS_W];
                disp_neg = disp[OFS_W-1];
                hi_base  = base_pc[PC_W-1:OFS_W];
                if (lo_carry && !disp_neg) begin
                    hi_adj = hi_base + {{(HI_W-1){1'b0}}, 1'b1};
                end else if (!lo_carry && disp_neg) begin
                    hi_adj = hi_base - {{(HI_W-1){1'b0}}, 1'b1};
                end else begin
                    hi_adj = hi_base;
                end
                sum_pc = {hi_adj, low_sum[OFS_W-1:0]};
            end
        end
    endgenerate

endmodule

// File: rtl/brx_branch_unit.sv
module brx_branch_unit
    import brx_pkg::*;
#(
    parameter int PC_W      = 16,
    parameter int OFS_W     = 8,
    parameter int ADD_STYLE = ADD_SPLIT
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic             in_valid,
    input  logic [2:0]       cond_sel,
    input  logic             flag_n,
    input  logic             flag_v,
    input  logic             flag_z,
    input  logic             flag_c,
    input  logic [PC_W-1:0]  next_pc,
    input  logic [OFS_W-1:0] offset,
    output logic             out_valid,
    output logic             taken,
    output logic [PC_W-1:0]  target
);

    localparam int SPAN = 1 << OFS_W;
    localparam logic [PC_W-1:0] HALF_SPAN = PC_W'(SPAN / 2);
    localparam logic [PC_W-1:0] FULL_SPAN = PC_W'(SPAN);

    typedef struct packed {
        logic            vld;
        logic            tkn;
        logic [PC_W-1:0] tgt;
    } stage_t;

    stage_t st_d, st_q;

    logic [FLAG_CNT-1:0] flag_vec;
    logic                cond_hit;
    logic [PC_W-1:0]     moved_pc;

    always_comb begin
        flag_vec          = '0;
        flag_vec[FLG_NEG] = flag_n;
        flag_vec[FLG_OVF] = flag_v;
        flag_vec[FLG_CRY] = flag_c;
        flag_vec[FLG_ZRO] = flag_z;
    end

    brx_cond_eval u_cond (
        .cond_sel (cond_sel),
        .flags    (flag_vec),
        .cond_true(cond_hit)
    );

    brx_target_add #(
        .PC_W     (PC_W),
        .OFS_W    (OFS_W),
        .ADD_STYLE(ADD_STYLE)
    ) u_add (
        .base_pc(next_pc),
        .disp   (offset),
        .sum_pc (moved_pc)
    );

    always_comb begin
        st_d     = st_q;
        st_d.vld = in_valid;
        if (in_valid) begin
            st_d.tkn = cond_hit;
            st_d.tgt = cond_hit ? moved_pc : next_pc;
        end
    end

    always_ff @(posedge clk) begin
        if (!rst_n) begin
            st_q <= '0;
        end else begin
            st_q <= st_d;
        end
    end

    assign out_valid = st_q.vld;
    assign taken     = st_q.tkn;
    assign target    = st_q.tgt;

    // R2: a request produces a result strobe on the next edge
    p_valid_follows_r2: assert property (@(posedge clk) disable iff (!rst_n)
        in_valid |=> out_valid);

    // R2: no strobe without a request
    p_no_spurious_valid_r2: assert property (@(posedge clk) disable iff (!rst_n)
        !in_valid |=> !out_valid);

    // R9: idle cycles leave the result untouched
    p_hold_idle_r9: assert property (@(posedge clk) disable iff (!rst_n)
        !in_valid |=> ($stable(taken) && $stable(target)));

    // R5: a branch that is not taken falls through
    p_fallthrough_r5: assert property (@(posedge clk) disable iff (!rst_n)
        in_valid |=> (taken || (target == $past(next_pc))));

    // R4: a taken target lies within the signed displacement range
    p_disp_range_r4: assert property (@(posedge clk) disable iff (!rst_n)
        in_valid |=> (!taken ||
            (PC_W'(target - $past(next_pc) + HALF_SPAN) < FULL_SPAN)));

    // R3: carry-set code with carry high is taken
    p_carry_set_r3: assert property (@(posedge clk) disable iff (!rst_n)
        (in_valid && cond_sel == 3'b101 && flag_c) |=> taken);

    // R3: zero-clear code with zero high is not taken
    p_zero_clear_r3: assert property (@(posedge clk) disable iff (!rst_n)
        (in_valid && cond_sel == 3'b110 && flag_z) |=> !taken);

endmodule

// File: tb/brx_branch_unit_tb_top.sv
`timescale 1ns/1ps
module brx_branch_unit_tb_top;

    logic        clk = 1'b0;
    logic        rst_n;
    logic        in_valid;
    logic [2:0]  cond_sel;
    logic        flag_n, flag_v, flag_z, flag_c;
    logic [15:0] next_pc;
    logic [7:0]  offset;
    logic        out_valid;
    logic        taken;
    logic [15:0] target;

    typedef struct {
        logic        tkn;
        logic [15:0] tgt;
        string       req;
    } exp_t;

    exp_t sb_q[$];
    int   checks = 0;
    int   failures = 0;
    bit   done = 1'b0;
    logic        last_tkn;
    logic [15:0] last_tgt;

    always #2.5 clk = ~clk;

    brx_branch_unit dut_i (
        .clk(clk), .rst_n(rst_n), .in_valid(in_valid), .cond_sel(cond_sel),
        .flag_n(flag_n), .flag_v(flag_v), .flag_z(flag_z), .flag_c(flag_c),
        .next_pc(next_pc), .offset(offset),
        .out_valid(out_valid), .taken(taken), .target(target)
    );

    task automatic check(input bit ok, input string req, input string what,
                         input logic [31:0] act, input logic [31:0] exp);
        checks++;
        if (!ok) begin
            failures++;
            $display("FAIL %s %s actual=%h expected=%h", req, what, act, exp);
        end
    endtask

    // Independent model of the branch decision from the requirement text
    function automatic logic model_taken(input logic [2:0] s, input logic n,
                                         input logic v, input logic z, input logic c);
        case (s)
            3'b000: return !n;
            3'b001: return  n;
            3'b010: return !v;
            3'b011: return  v;
            3'b100: return !c;
            3'b101: return  c;
            3'b110: return !z;
            default: return z;
        endcase
    endfunction

    task automatic send(input logic [2:0] s, input logic [3:0] nvzc,
                        input logic [15:0] pc, input logic [7:0] ofs, input string req);
        exp_t e;
        logic [15:0] ext;
        @(negedge clk);
        in_valid = 1'b1;
        cond_sel = s;
        {flag_n, flag_v, flag_z, flag_c} = nvzc;
        next_pc = pc;
        offset  = ofs;
        ext   = {{8{ofs[7]}}, ofs};
        e.tkn = model_taken(s, nvzc[3], nvzc[2], nvzc[1], nvzc[0]);
        e.tgt = e.tkn ? pc + ext : pc;
        e.req = req;
        sb_q.push_back(e);
        last_tkn = e.tkn;
        last_tgt = e.tgt;
    endtask

    // Idle cycle with scrambled side inputs; outputs must hold (R9, R2)
    task automatic idle_hold();
        @(negedge clk);
        in_valid = 1'b0;
        cond_sel = ~cond_sel;
        next_pc  = next_pc ^ 16'h5A5A;
        offset   = offset ^ 8'hC3;
        flag_c   = ~flag_c;
        @(negedge clk);
        check(out_valid == 1'b0, "R2", "out_valid during idle", 32'(out_valid), 32'd0);
        check(taken == last_tkn, "R9", "taken hold", 32'(taken), 32'(last_tkn));
        check(target == last_tgt, "R9", "target hold", 32'(target), 32'(last_tgt));
    endtask

    // Monitor: compare each strobed result with the scoreboard head
    always @(negedge clk) begin
        if (rst_n === 1'b1 && out_valid === 1'b1) begin
            if (sb_q.size() == 0) begin
                check(1'b0, "R2", "unexpected out_valid", 32'd1, 32'd0);
            end else begin
                exp_t e;
                e = sb_q.pop_front();
                check(taken == e.tkn, e.req, "taken", 32'(taken), 32'(e.tkn));
                check(target == e.tgt, e.req, "target", 32'(target), 32'(e.tgt));
            end
        end
    end

    initial begin
        #200000;
        if (!done) begin
            failures++;
            checks++;
            $display("FAIL watchdog expired");
            $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
            $finish;
        end
    end

    initial begin
        rst_n = 1'b0; in_valid = 1'b0; cond_sel = '0;
        {flag_n, flag_v, flag_z, flag_c} = '0;
        next_pc = 16'h1234; offset = 8'h10;
        repeat (3) @(negedge clk);
        check(out_valid == 1'b0, "R1", "out_valid in reset", 32'(out_valid), 32'd0);
        check(taken == 1'b0, "R1", "taken in reset", 32'(taken), 32'd0);
        check(target == 16'h0, "R1", "target in reset", 32'(target), 32'd0);
        in_valid = 1'b1;
        @(negedge clk);
        check(out_valid == 1'b0, "R1", "valid ignored in reset", 32'(out_valid), 32'd0);
        in_valid = 1'b0;
        rst_n = 1'b1;
        @(negedge clk);
        check(target == 16'h0, "R1", "target after release", 32'(target), 32'd0);

        // R3: every code with its flag set and cleared (flags NVZC)
        for (int s = 0; s < 8; s++) begin
            send(3'(s), 4'b1111, 16'h4000, 8'h05, "R3");
            send(3'(s), 4'b0000, 16'h4000, 8'h05, "R3");
        end
        // R3: only the selected flag matters
        send(3'b101, 4'b1110, 16'h4000, 8'h05, "R3");
        send(3'b010, 4'b1011, 16'h4000, 8'h05, "R3");

        // R4 forward and backward inside a page
        send(3'b001, 4'b1000, 16'h2040, 8'h10, "R4");
        send(3'b001, 4'b1000, 16'h2040, 8'hF0, "R4");
        // R5 not taken with a nonzero offset
        send(3'b111, 4'b0000, 16'h3456, 8'h7F, "R5");
        // R6 zero offset
        send(3'b011, 4'b0100, 16'h5678, 8'h00, "R6");
        // R7 page crossings and extremes
        send(3'b101, 4'b0001, 16'h10F0, 8'h20, "R7");
        send(3'b101, 4'b0001, 16'h1005, 8'hF0, "R7");
        send(3'b101, 4'b0001, 16'h1080, 8'h7F, "R7");
        send(3'b101, 4'b0001, 16'h1010, 8'h80, "R7");
        // R8 wrap both ways
        send(3'b110, 4'b0000, 16'hFFF0, 8'h20, "R8");
        send(3'b110, 4'b0000, 16'h0005, 8'hF0, "R8");

        idle_hold();
        send(3'b000, 4'b0000, 16'h7FFF, 8'h01, "R4");
        idle_hold();
        idle_hold();

        repeat (3) @(negedge clk);
        check(sb_q.size() == 0, "R2", "results pending", 32'(sb_q.size()), 32'd0);
        done = 1'b1;
        $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
        $finish;
    end

endmodule